// File: doc/BRIEF.md
# Serial Transmit Line Encoder with Preamble

This block turns a stream of bytes into a single encoded transmit line. When a byte is offered while the block is idle, the block first sends a preamble. The preamble is either a fixed pattern or a run of repeated flag characters, and its length is configurable. It then shifts out the data bits, least-significant bit first. Each bit is line-coded according to a three-bit mode field. The final character of a frame may be shorter than a full byte.

Timing comes from a half-cell enable `cell_tick`. Every bit cell spans two consecutive ticks, so biphase coding gets its mid-cell transition and level codes simply hold for both halves. All configuration inputs are read live and must be held steady while `busy` is high. Bytes are taken over a ready/valid handshake that can only complete on a tick.

Top module: `sertx_line_tx`

## Requirements
- R1: After reset, `busy` is 0, `tx_line` is 0, and `in_ready` is 0 whenever `cell_tick` is 0.
- R2: `in_ready` is high only on a tick. It is high on every tick while idle, and on the mid-cell tick of the final bit of a byte that is not marked last. A byte transfers when `in_valid` and `in_ready` are both 1, and a frame starts only on such a transfer while idle.
- R3: `tx_line` changes only on a tick. The first cell of a frame begins on the tick after the accepting tick, and each cell occupies exactly two ticks.
- R4: Preamble pattern `cfg_pat`: 0 gives all zeros, 1 gives all ones, 2 gives 1,0,1,0… (starting with 1), and 3 gives 0,1,0,1… (starting with 0).
- R5: Preamble length `cfg_plen`: 0, 1, 2 and 3 give 8, 16, 32 and 64 bits.
- R6: When `cfg_flag` is 1, the preamble bits are the character 0x7E repeated and sent LSB first, with `cfg_pat` ignored and the length still set by `cfg_plen`.
- R7: Data bits follow the preamble, LSB first. When a further byte is offered at the boundary, it follows with no gap. The frame ends after a byte marked `in_last`, or after any byte when no new byte is valid at its final mid-cell tick.
- R8: A byte marked `in_last` sends `cfg_lastlen` bits (its low bits), where value 0 means all 8 bits.
- R9: `cfg_enc` 0 sends the bit level (NRZ), 1 sends its inverse, and codes 5, 6 and 7 behave as 0. With these codes the line is constant across a cell.
- R10: `cfg_enc` 2 toggles the line at cell start when the bit is 1. `cfg_enc` 3 toggles it at cell start when the bit is 0.
- R11: `cfg_enc` 4 (biphase mark) toggles the line at every cell start, and toggles it again at mid-cell when the bit is 1.
- R12: `busy` rises after the accepting tick and falls after the tick that ends the last cell. Between frames the line keeps its last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_tick | input | 1 | Half-bit-cell enable |
| in_valid | input | 1 | Byte offered |
| in_data | input | DATA_W | Byte to send |
| in_last | input | 1 | Byte is the final character of the frame |
| in_ready | output | 1 | Byte accepted this cycle when valid |
| cfg_pat | input | 2 | Preamble pattern select |
| cfg_plen | input | 2 | Preamble length select |
| cfg_flag | input | 1 | Send flag characters as preamble |
| cfg_enc | input | 3 | Line code select |
| cfg_lastlen | input | LEN_W | Bit count of the final character, 0 = full |
| tx_line | output | 1 | Encoded serial line |
| busy | output | 1 | Frame in progress |

## Verification
`tx_line` is registered, so the level for half-cell k of a frame is visible one clock after the k-th tick following the accepting tick. `busy` falls one clock after the tick that follows the last half-cell. The bench records the clocks on which it raised `cell_tick`. It samples the outputs at the next falling edge after each such tick and compares them with a half-cell level list worked out beforehand from the configuration and the bytes. On non-tick cycles it checks that the line kept its previous value. `in_ready` is combinational on the tick and state, so the bench reads it 1 ns after it drives the inputs, before the rising edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PRE  = 2'd1,
    SEQ_DATA = 2'd2,
    SEQ_FIN  = 2'd3
  } seq_state_e;

  localparam logic [2:0] LC_NRZ    = 3'd0;
  localparam logic [2:0] LC_NRZ_INV = 3'd1;
  localparam logic [2:0] LC_NRZI_M = 3'd2;
  localparam logic [2:0] LC_NRZI_S = 3'd3;
  localparam logic [2:0] LC_BIPH_M = 3'd4;

  localparam logic [1:0] PAT_ZERO = 2'd0;
  localparam logic [1:0] PAT_ONE  = 2'd1;
  localparam logic [1:0] PAT_ALT1 = 2'd2;
  localparam logic [1:0] PAT_ALT0 = 2'd3;

endpackage

// File: rtl/sertx_rst_sync.sv
module sertx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/sertx_pre_gen.sv
module sertx_pre_gen #(
  parameter int          IDX_W     = 6,
  parameter int          PRE_BASE  = 8,
  parameter int          FLAG_W    = 8,
  parameter logic [FLAG_W-1:0] FLAG_WORD = 8'h7E
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       cfg_pat,
  input  logic [1:0]       cfg_plen,
  input  logic             cfg_flag,
  output logic             pre_bit,
  output logic             pre_end
);
  import sertx_pkg::*;

  localparam int FSEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1;

  logic [IDX_W-1:0] len_m1;
  logic [FSEL_W-1:0] fsel;
  logic              pat_bit;

  always_comb begin
    len_m1 = IDX_W'((PRE_BASE << cfg_plen) - 1);
    pre_end = (idx == len_m1);
  end

  always_comb begin
    fsel = FSEL_W'(idx % FLAG_W);
    case (cfg_pat)
      PAT_ZERO: pat_bit = 1'b0;
      PAT_ONE:  pat_bit = 1'b1;
      PAT_ALT1: pat_bit = ~idx[0];
      default:  pat_bit = idx[0];
    endcase
    pre_bit = cfg_flag ? FLAG_WORD[fsel] : pat_bit;
  end

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  cfg_lastlen,
  input  logic              pre_bit,
  input  logic              pre_end,
  output logic [IDX_W-1:0]  idx,
  output logic              cell_first,
  output logic              cell_second,
  output logic              bit_val,
  output logic              busy
);
  import sertx_pkg::*;

  seq_state_e        st_q, st_n;
  logic              half_q, half_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              last_q, last_n;
  logic [IDX_W-1:0]  byte_m1;
  logic              in_cell;

  always_comb begin
    if (last_q && (cfg_lastlen != '0)) byte_m1 = IDX_W'(cfg_lastlen) - 1'b1;
    else                               byte_m1 = IDX_W'(DATA_W - 1);
  end

  always_comb begin
    st_n     = st_q;
    half_n   = half_q;
    idx_n    = idx_q;
    sh_n     = sh_q;
    last_n   = last_q;
    in_ready = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (cell_tick) begin
          in_ready = 1'b1;
          if (in_valid) begin
            st_n   = SEQ_PRE;
            sh_n   = in_data;
            last_n = in_last;
            idx_n  = '0;
            half_n = 1'b0;
          end
        end
      end
      SEQ_PRE: begin
        if (cell_tick) begin
          half_n = ~half_q;
          if (half_q) begin
            if (pre_end) begin
              st_n  = SEQ_DATA;
              idx_n = '0;
            end else begin
              idx_n = idx_q + 1'b1;
            end
          end
        end
      end
      SEQ_DATA: begin
        if (cell_tick) begin
          half_n = ~half_q;
          if (half_q) begin
            if (idx_q == byte_m1) begin
              if (last_q) begin
                st_n = SEQ_FIN;
              end else begin
                in_ready = 1'b1;
                if (in_valid) begin
                  sh_n   = in_data;
                  last_n = in_last;
                  idx_n  = '0;
                end else begin
                  st_n = SEQ_FIN;
                end
              end
            end else begin
              idx_n = idx_q + 1'b1;
              sh_n  = sh_q >> 1;
            end
          end
        end
      end
      default: begin
        if (cell_tick) st_n = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      half_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      half_q <= half_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      last_q <= last_n;
    end
  end

  assign in_cell     = (st_q == SEQ_PRE) || (st_q == SEQ_DATA);
  assign cell_first  = cell_tick && in_cell && !half_q;
  assign cell_second = cell_tick && in_cell && half_q;
  assign bit_val     = (st_q == SEQ_PRE) ? pre_bit : sh_q[0];
  assign busy        = (st_q != SEQ_IDLE);
  assign idx         = idx_q;

endmodule

// File: rtl/sertx_line_enc.sv
module sertx_line_enc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_enc,
  input  logic       cell_first,
  input  logic       cell_second,
  input  logic       bit_val,
  output logic       tx_line
);
  import sertx_pkg::*;

  logic line_q, line_n;

  always_comb begin
    line_n = line_q;
    if (cell_first) begin
      case (cfg_enc)
        LC_NRZ_INV: line_n = ~bit_val;
        LC_NRZI_M:  line_n = line_q ^ bit_val;
        LC_NRZI_S:  line_n = line_q ^ ~bit_val;
        LC_BIPH_M:  line_n = ~line_q;
        default:    line_n = bit_val;
      endcase
    end else if (cell_second && (cfg_enc == LC_BIPH_M)) begin
      line_n = line_q ^ bit_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else        line_q <= line_n;
  end

  assign tx_line = line_q;

endmodule

// File: rtl/sertx_line_tx.sv
module sertx_line_tx #(
  parameter int          DATA_W    = 8,
  parameter int          PRE_BASE  = 8,
  parameter logic [7:0]  FLAG_WORD = 8'h7E,
  localparam int         LEN_W     = $clog2(DATA_W),
  localparam int         PRE_MAX   = PRE_BASE * 8,
  localparam int         IDX_W     = ($clog2(PRE_MAX) > LEN_W) ? $clog2(PRE_MAX) : LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic [1:0]        cfg_pat,
  input  logic [1:0]        cfg_plen,
  input  logic              cfg_flag,
  input  logic [2:0]        cfg_enc,
  input  logic [LEN_W-1:0]  cfg_lastlen,
  output logic              tx_line,
  output logic              busy
);

  logic             rst_sync_n;
  logic [IDX_W-1:0] idx;
  logic             pre_bit;
  logic             pre_end;
  logic             cell_first;
  logic             cell_second;
  logic             bit_val;

  sertx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sertx_pre_gen #(
    .IDX_W     (IDX_W),
    .PRE_BASE  (PRE_BASE),
    .FLAG_W    (8),
    .FLAG_WORD (FLAG_WORD)
  ) u_pre (
    .idx      (idx),
    .cfg_pat  (cfg_pat),
    .cfg_plen (cfg_plen),
    .cfg_flag (cfg_flag),
    .pre_bit  (pre_bit),
    .pre_end  (pre_end)
  );

  sertx_seq #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .LEN_W  (LEN_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cell_tick   (cell_tick),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .cfg_lastlen (cfg_lastlen),
    .pre_bit     (pre_bit),
    .pre_end     (pre_end),
    .idx         (idx),
    .cell_first  (cell_first),
    .cell_second (cell_second),
    .bit_val     (bit_val),
    .busy        (busy)
  );

  sertx_line_enc u_enc (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cfg_enc     (cfg_enc),
    .cell_first  (cell_first),
    .cell_second (cell_second),
    .bit_val     (bit_val),
    .tx_line     (tx_line)
  );

endmodule

// File: rtl/sertx_line_tx_chk.sv
module sertx_line_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cell_tick,
  input logic       in_valid,
  input logic       in_ready,
  input logic       busy,
  input logic       tx_line,
  input logic [2:0] cfg_enc,
  input logic       cell_first,
  input logic       cell_second
);

  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_tick |=> $stable(tx_line));

  // R2
  ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> cell_tick);

  // R12
  idle_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !in_valid) |=> !busy);

  // R2
  start_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && in_ready));

  // R11
  biph_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_first && cfg_enc == 3'd4) |=> (tx_line != $past(tx_line)));

  // R9
  level_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_second && cfg_enc != 3'd4) |=> $stable(tx_line));

endmodule

bind sertx_line_tx sertx_line_tx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cell_tick   (cell_tick),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .busy        (busy),
  .tx_line     (tx_line),
  .cfg_enc     (cfg_enc),
  .cell_first  (cell_first),
  .cell_second (cell_second)
);

// File: tb/sertx_line_tx_bench.sv
`timescale 1ns/1ps
module sertx_line_tx_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cell_tick;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready;
  logic [1:0] cfg_pat;
  logic [1:0] cfg_plen;
  logic       cfg_flag;
  logic [2:0] cfg_enc;
  logic [2:0] cfg_lastlen;
  logic       tx_line;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;
  bit finished = 0;

  logic [7:0] q_data [8];
  logic       q_last [8];
  int         q_n;
  logic       exp_lv [512];
  int         exp_n;
  int         pre_halves;

  always #2.5 clk = ~clk;

  sertx_line_tx u_sertx_line_tx (
    .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .cfg_pat(cfg_pat), .cfg_plen(cfg_plen), .cfg_flag(cfg_flag),
    .cfg_enc(cfg_enc), .cfg_lastlen(cfg_lastlen), .tx_line(tx_line), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic logic pre_model(input int i);
    logic [7:0] flag = 8'h7E;
    if (cfg_flag) return flag[i % 8];
    case (cfg_pat)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return (i % 2 == 0);
      default: return (i % 2 == 1);
    endcase
  endfunction

  task automatic push_bit(input logic b, inout logic lv);
    logic h0, h1;
    case (cfg_enc)
      3'd1: begin h0 = ~b; h1 = ~b; end
      3'd2: begin h0 = lv ^ b; h1 = h0; end
      3'd3: begin h0 = lv ^ ~b; h1 = h0; end
      3'd4: begin h0 = ~lv; h1 = h0 ^ b; end
      default: begin h0 = b; h1 = b; end
    endcase
    exp_lv[exp_n] = h0;
    exp_lv[exp_n+1] = h1;
    exp_n += 2;
    lv = h1;
  endtask

  task automatic build_exp(input logic start_lvl);
    logic lv = start_lvl;
    int npre = 8 << cfg_plen;
    exp_n = 0;
    for (int i = 0; i < npre; i++) push_bit(pre_model(i), lv);
    pre_halves = exp_n;
    for (int j = 0; j < q_n; j++) begin
      int len = 8;
      if (q_last[j] && cfg_lastlen != 0) len = int'(cfg_lastlen);
      for (int i = 0; i < len; i++) push_bit(q_data[j][i], lv);
      if (q_last[j]) break;
    end
  endtask

  function automatic string enc_tag();
    case (cfg_enc)
      3'd2, 3'd3: return "R10";
      3'd4: return "R11";
      default: return "R9";
    endcase
  endfunction

  task automatic run_frame(input int div);
    logic start_lvl;
    logic last_seen;
    int ptr = 0;
    int k = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;
    bit prev_tick = 0;
    string tg;
    @(negedge clk);
    start_lvl = tx_line;
    last_seen = tx_line;
    build_exp(start_lvl);
    while (!done) begin
      @(negedge clk);
      if (started) begin
        if (prev_tick) begin
          if (k >= 1 && k <= exp_n) begin
            tg = (k <= pre_halves) ? (cfg_flag ? "R6 R5" : "R4 R5") : "R7 R8";
            check(tx_line === exp_lv[k-1], {tg, " ", enc_tag()}, int'(tx_line), int'(exp_lv[k-1]));
            check(busy === 1'b1, "R12 busy in frame", int'(busy), 1);
          end else if (k > exp_n) begin
            check(busy === 1'b0, "R12 busy end", int'(busy), 0);
            check(ptr == q_n, "R7 bytes taken", ptr, q_n);
            done = 1;
          end
          k++;
        end else begin
          check(tx_line === last_seen, "R3 hold between ticks", int'(tx_line), int'(last_seen));
        end
      end
      last_seen = tx_line;
      if (!done) begin
        cell_tick = (cyc % div == 0);
        in_valid  = (ptr < q_n);
        in_data   = q_data[ptr % 8];
        in_last   = q_last[ptr % 8];
        #1;
        if (!cell_tick) check(in_ready === 1'b0, "R2 ready without tick", int'(in_ready), 0);
        if (in_ready && in_valid) begin
          if (ptr == 0) started = 1;
          ptr++;
        end
        prev_tick = cell_tick;
        cyc++;
      end
    end
    cell_tick = 1'b0;
    in_valid  = 1'b0;
    in_last   = 1'b0;
  endtask

  task automatic load_q(input int n, input bit mark_last, input int seed);
    q_n = n;
    for (int j = 0; j < 8; j++) begin
      q_data[j] = 8'(seed * 37 + j * 75 + 19);
      q_last[j] = mark_last && (j == n - 1);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", cyc_total, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cell_tick = 1'b0; in_valid = 1'b0; in_data = '0; in_last = 1'b0;
    cfg_pat = '0; cfg_plen = '0; cfg_flag = 1'b0; cfg_enc = '0; cfg_lastlen = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy", int'(busy), 0);
    check(tx_line === 1'b0, "R1 line", int'(tx_line), 0);
    check(in_ready === 1'b0, "R1 ready", int'(in_ready), 0);

    // every code against every pattern
    for (int e = 0; e < 8; e++) begin
      for (int p = 0; p < 4; p++) begin
        cfg_enc = 3'(e); cfg_pat = 2'(p); cfg_plen = 2'd0; cfg_flag = 1'b0; cfg_lastlen = 3'd0;
        load_q(2, 1, e * 4 + p);
        run_frame((e % 2 == 1) ? 1 : 3);
      end
    end
    // preamble lengths, with and without flags
    for (int l = 0; l < 4; l++) begin
      for (int f = 0; f < 2; f++) begin
        cfg_enc = 3'd4; cfg_pat = 2'd2; cfg_plen = 2'(l); cfg_flag = 1'(f); cfg_lastlen = 3'd0;
        load_q(1, 1, l * 2 + f);
        run_frame(2);
      end
    end
    // short final character, all lengths
    for (int n = 0; n < 8; n++) begin
      cfg_enc = 3'(2 + n % 3); cfg_pat = 2'd3; cfg_plen = 2'd0; cfg_flag = 1'b0; cfg_lastlen = 3'(n);
      load_q(3, 1, 50 + n);
      run_frame(1);
    end
    // underrun: no byte marked last
    cfg_enc = 3'd3; cfg_pat = 2'd1; cfg_plen = 2'd1; cfg_flag = 1'b0; cfg_lastlen = 3'd5;
    load_q(2, 0, 99);
    run_frame(3);
    // line keeps level between frames
    repeat (6) @(negedge clk);
    check(busy === 1'b0, "R12 idle after frames", int'(busy), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule